// File: doc/BRIEF.md
# Guarded Fixed-Point Multiply-Accumulate Unit

This block multiplies two 16-bit operands and folds the product into a 40-bit accumulator in a single clock, with no pipeline. Each operand can be treated as signed or unsigned. The block extends each operand by one bit and multiplies them in a 17 x 17 signed multiplier. In fractional mode the product is doubled, which removes the duplicated sign bit of a Q15 x Q15 product so that the result lines up with Q15 data.

The accumulator holds 8 guard bits above a 32-bit value, so long sums of full-scale products stay exact. Rounding can be requested on any multiply operation. A saturate strobe limits the result to the signed 32-bit range. Both the full accumulator and its middle 16-bit word (bits 31:16, the Q15 result) are presented on registered outputs.

Top module: `mac_guard_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator and the high-word output become zero after that edge.
- R2: Op code 2 (load product) replaces the accumulator with the product, sign-extended to 40 bits.
- R3: Op code 3 adds the sign-extended product to the accumulator, and op code 4 subtracts it. Both complete in one clock.
- R4: When `frac` is 1, the product is shifted left by one bit before it is used. For example, 0x8000 x 0x8000 gives 0x0080000000.
- R5: `a_uns` / `b_uns` set to 1 zero-extend that operand to 17 bits. When they are 0, the operand is sign-extended.
- R6: When `rnd` is 1 on op codes 2, 3 or 4, 0x8000 is added to the new accumulator value and bits 15:0 are then cleared.
- R7: When `sat` is 1, a new accumulator value outside the signed 32-bit range is replaced by 0x007FFFFFFF (if positive) or 0xFF80000000 (if negative). Values inside the range pass unchanged.
- R8: Without `sat`, the accumulator wraps modulo 2^40.
- R9: Op code 1 clears the accumulator, and op code 0 leaves it unchanged.
- R10: `acc_hi` always equals bits 31:16 of `acc`.
- R11: 256 accumulations of the largest non-fractional product, 0x8000 x 0x8000, give exactly 0x4000000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 3 | 0 hold, 1 clear, 2 load product, 3 accumulate, 4 subtract |
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| a_uns | input | 1 | Treat `a` as unsigned |
| b_uns | input | 1 | Treat `b` as unsigned |
| frac | input | 1 | Fractional mode: double the product |
| rnd | input | 1 | Round the result of a multiply operation |
| sat | input | 1 | Clamp the result to the signed 32-bit range |
| acc | output | 40 | Accumulator |
| acc_hi | output | 16 | Accumulator bits 31:16 |

## Verification
The properties assume that `op` carries only the codes 0 to 4 and that every control input is a known level at each clock edge. The hold and rounding properties also assume that `sat` is low in those cycles, because a clamp may otherwise change the value. The bench drives every input at the falling edge from a fixed table or from directed sequences, so each input is stable across the rising edge. It uses only defined op codes and asserts saturation only in cycles where its effect on the result is part of the expected value.

// File: rtl/mac_guard_pkg.sv
package mac_guard_pkg;
  localparam int OP_BITS = 3;
  typedef enum logic [OP_BITS-1:0] {
    OP_NOP = 3'd0,
    OP_CLR = 3'd1,
    OP_MPY = 3'd2,
    OP_MAC = 3'd3,
    OP_MAS = 3'd4
  } mac_op_e;
endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int OP_W = 16,
  localparam int EXT_W = OP_W + 1,
  localparam int PROD_W = 2 * EXT_W + 1
) (
  input  logic [OP_W-1:0]          a,
  input  logic [OP_W-1:0]          b,
  input  logic                     a_uns,
  input  logic                     b_uns,
  input  logic                     frac,
  output logic signed [PROD_W-1:0] prod
);
  logic signed [EXT_W-1:0]   a_ext, b_ext;
  logic signed [2*EXT_W-1:0] raw;

  always_comb begin
    a_ext = {(a_uns ? 1'b0 : a[OP_W-1]), a};
    b_ext = {(b_uns ? 1'b0 : b[OP_W-1]), b};
    raw   = a_ext * b_ext;
    if (frac) prod = {raw, 1'b0};
    else      prod = {raw[2*EXT_W-1], raw};
  end
endmodule

// File: rtl/mac_accum.sv
module mac_accum
  import mac_guard_pkg::*;
#(
  parameter int ACC_W = 40,
  parameter int PROD_W = 35,
  parameter int RND_POS = 15
) (
  input  logic [ACC_W-1:0]  acc,
  input  logic [PROD_W-1:0] prod,
  input  mac_op_e           op,
  input  logic              rnd,
  output logic [ACC_W-1:0]  nxt
);
  localparam logic [ACC_W-1:0] RND_ADD  = ACC_W'(1) << RND_POS;
  localparam logic [ACC_W-1:0] RND_MASK = ~((ACC_W'(1) << (RND_POS + 1)) - ACC_W'(1));

  logic [ACC_W-1:0] p_ext, sum;
  logic             is_mul;

  always_comb begin
    p_ext  = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
    is_mul = 1'b1;
    unique case (op)
      OP_CLR:  begin sum = '0;          is_mul = 1'b0; end
      OP_MPY:  sum = p_ext;
      OP_MAC:  sum = acc + p_ext;
      OP_MAS:  sum = acc - p_ext;
      default: begin sum = acc;         is_mul = 1'b0; end
    endcase
    if (rnd && is_mul) nxt = (sum + RND_ADD) & RND_MASK;
    else               nxt = sum;
  end
endmodule

// File: rtl/mac_sat.sv
module mac_sat #(
  parameter int ACC_W = 40,
  parameter int SAT_W = 32
) (
  input  logic [ACC_W-1:0] din,
  input  logic             en,
  output logic [ACC_W-1:0] dout
);
  localparam int TOP_W = ACC_W - SAT_W + 1;
  localparam logic [ACC_W-1:0] POS_LIM = (ACC_W'(1) << (SAT_W - 1)) - ACC_W'(1);
  localparam logic [ACC_W-1:0] NEG_LIM = ~POS_LIM;

  logic [TOP_W-1:0] top;
  logic             in_range;

  always_comb begin
    top      = din[ACC_W-1:SAT_W-1];
    in_range = (top == '0) || (top == '1);
    if (!en || in_range)  dout = din;
    else if (din[ACC_W-1]) dout = NEG_LIM;
    else                  dout = POS_LIM;
  end
endmodule

// File: rtl/mac_guard_unit.sv
module mac_guard_unit
  import mac_guard_pkg::*;
#(
  parameter int OP_W = 16,
  parameter int GUARD_W = 8,
  localparam int ACC_W = 2 * OP_W + GUARD_W,
  localparam int PROD_W = 2 * (OP_W + 1) + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [OP_BITS-1:0] op,
  input  logic [OP_W-1:0]    a,
  input  logic [OP_W-1:0]    b,
  input  logic               a_uns,
  input  logic               b_uns,
  input  logic               frac,
  input  logic               rnd,
  input  logic               sat,
  output logic [ACC_W-1:0]   acc,
  output logic [OP_W-1:0]    acc_hi
);
  logic [PROD_W-1:0] prod;
  logic [ACC_W-1:0]  acc_q, sum_nxt, sat_nxt;

  mac_mult #(.OP_W(OP_W)) u_mult (
    .a(a), .b(b), .a_uns(a_uns), .b_uns(b_uns), .frac(frac), .prod(prod)
  );

  mac_accum #(.ACC_W(ACC_W), .PROD_W(PROD_W), .RND_POS(OP_W-1)) u_accum (
    .acc(acc_q), .prod(prod), .op(mac_op_e'(op)), .rnd(rnd), .nxt(sum_nxt)
  );

  mac_sat #(.ACC_W(ACC_W), .SAT_W(2*OP_W)) u_sat (
    .din(sum_nxt), .en(sat), .dout(sat_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      acc_hi <= '0;
    end else begin
      acc_q  <= sat_nxt;
      acc_hi <= sat_nxt[2*OP_W-1:OP_W];
    end
  end

  assign acc = acc_q;
endmodule

// File: rtl/mac_guard_unit_chk.sv
module mac_guard_unit_chk #(
  parameter int ACC_W = 40,
  parameter int SAT_W = 32,
  parameter int RND_LOW = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       op,
  input logic             rnd,
  input logic             sat,
  input logic [ACC_W-1:0] acc
);
  // R1: reset clears the accumulator
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> acc == '0);

  // R9: clear op gives zero, hold op keeps the value
  assert_clear_zero_R9: assert property (@(posedge clk) disable iff (rst)
    op == 3'd1 |=> acc == '0);
  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd0 && !sat) |=> $stable(acc));

  // R6: rounded multiply results have an empty low word
  assert_round_low_R6: assert property (@(posedge clk) disable iff (rst)
    (rnd && !sat && (op == 3'd2 || op == 3'd3 || op == 3'd4)) |=> acc[RND_LOW-1:0] == '0);

  // R7: after a saturate strobe the value sits in the signed 32-bit range
  assert_sat_range_R7: assert property (@(posedge clk) disable iff (rst)
    sat |=> (acc[ACC_W-1:SAT_W-1] == '0 || acc[ACC_W-1:SAT_W-1] == '1));
endmodule

bind mac_guard_unit mac_guard_unit_chk #(.ACC_W(ACC_W), .SAT_W(2*OP_W), .RND_LOW(OP_W)) u_chk (
  .clk(clk), .rst(rst), .op(op), .rnd(rnd), .sat(sat), .acc(acc_q)
);

// File: tb/mac_guard_unit_tb.sv
module mac_guard_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  op;
  logic [15:0] a, b;
  logic        a_uns, b_uns, frac, rnd, sat;
  logic [39:0] acc;
  logic [15:0] acc_hi;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  mac_guard_unit u_dut (
    .clk(clk), .rst(rst), .op(op), .a(a), .b(b), .a_uns(a_uns), .b_uns(b_uns),
    .frac(frac), .rnd(rnd), .sat(sat), .acc(acc), .acc_hi(acc_hi)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] a;
    logic [15:0] b;
    logic        ua, ub, fr, rd, st;
    logic [39:0] exp;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{3'd2, 16'h0003, 16'h0004, 1'b0,1'b0,1'b0,1'b0,1'b0, 40'h000000000C}, // R2
    '{3'd3, 16'hFFFB, 16'h0007, 1'b0,1'b0,1'b0,1'b0,1'b0, 40'hFFFFFFFFE9}, // R3 add
    '{3'd4, 16'hFFFB, 16'h0007, 1'b0,1'b0,1'b0,1'b0,1'b0, 40'h000000000C}, // R3 sub
    '{3'd2, 16'h4000, 16'h4000, 1'b0,1'b0,1'b1,1'b0,1'b0, 40'h0020000000}, // R4
    '{3'd2, 16'hFFFF, 16'hFFFF, 1'b1,1'b1,1'b0,1'b0,1'b0, 40'h00FFFE0001}, // R5 both unsigned
    '{3'd2, 16'hFFFF, 16'hFFFF, 1'b0,1'b0,1'b0,1'b0,1'b0, 40'h0000000001}, // R5 both signed
    '{3'd2, 16'hFFFF, 16'hFFFF, 1'b1,1'b0,1'b0,1'b0,1'b0, 40'hFFFFFF0001}, // R5 mixed
    '{3'd2, 16'h0003, 16'h4000, 1'b0,1'b0,1'b0,1'b1,1'b0, 40'h0000010000}, // R6 round up
    '{3'd3, 16'h0001, 16'h7FFF, 1'b0,1'b0,1'b0,1'b1,1'b0, 40'h0000010000}, // R6 round down
    '{3'd0, 16'h0005, 16'h0005, 1'b0,1'b0,1'b0,1'b0,1'b0, 40'h0000010000}, // R9 hold
    '{3'd1, 16'h0005, 16'h0005, 1'b0,1'b0,1'b0,1'b0,1'b0, 40'h0000000000}, // R9 clear
    '{3'd2, 16'h8000, 16'h8000, 1'b0,1'b0,1'b1,1'b0,1'b0, 40'h0080000000}, // R4 corner
    '{3'd3, 16'h0000, 16'h0000, 1'b0,1'b0,1'b0,1'b0,1'b1, 40'h007FFFFFFF}, // R7 positive clamp
    '{3'd4, 16'h7FFF, 16'h7FFF, 1'b0,1'b0,1'b0,1'b0,1'b1, 40'h004000FFFE}, // R7 in range
    '{3'd2, 16'h8000, 16'h7FFF, 1'b0,1'b0,1'b1,1'b0,1'b1, 40'hFF80010000}, // R7 in range neg
    '{3'd3, 16'h8000, 16'h7FFF, 1'b0,1'b0,1'b1,1'b0,1'b1, 40'hFF80000000}, // R7 negative clamp
    '{3'd3, 16'h8000, 16'h8000, 1'b0,1'b0,1'b1,1'b0,1'b0, 40'h0000000000}  // R3 frac add
  };

  task automatic check40(input string req, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s acc actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s acc_hi actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] o, input logic [15:0] x, input logic [15:0] y,
                       input logic ux, input logic uy, input logic f, input logic r, input logic s);
    op = o; a = x; b = y; a_uns = ux; b_uns = uy; frac = f; rnd = r; sat = s;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    drive(3'd0, '0, '0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    check40("R1", acc, 40'h0);
    check16("R1", acc_hi, 16'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].op, VEC[i].a, VEC[i].b, VEC[i].ua, VEC[i].ub, VEC[i].fr, VEC[i].rd, VEC[i].st);
      @(negedge clk);
      check40($sformatf("vec%0d", i), acc, VEC[i].exp);
      check16($sformatf("R10 vec%0d", i), acc_hi, VEC[i].exp[31:16]);
    end

    // R11: 256 full-scale products stay exact in the guard bits
    drive(3'd1, '0, '0, 0, 0, 0, 0, 0);
    @(negedge clk);
    drive(3'd3, 16'h8000, 16'h8000, 0, 0, 0, 0, 0);
    repeat (256) @(negedge clk);
    drive(3'd0, '0, '0, 0, 0, 0, 0, 0);
    check40("R11", acc, 40'h4000000000);
    check16("R10 guard", acc_hi, 16'h0000);

    // R8: another 256 wraps past the 40-bit signed limit
    drive(3'd3, 16'h8000, 16'h8000, 0, 0, 0, 0, 0);
    repeat (256) @(negedge clk);
    drive(3'd0, '0, '0, 0, 0, 0, 0, 0);
    check40("R8", acc, 40'h8000000000);

    // R8: one more product past the wrap point, then saturate it (R7)
    drive(3'd4, 16'h0001, 16'h0001, 0, 0, 0, 0, 0);
    @(negedge clk);
    check40("R8", acc, 40'h7FFFFFFFFF);
    drive(3'd0, '0, '0, 0, 0, 0, 0, 1);
    @(negedge clk);
    check40("R7", acc, 40'h007FFFFFFF);
    check16("R10", acc_hi, 16'h7FFF);

    // R1: reset in the middle of operation
    drive(3'd3, 16'h1234, 16'h0100, 0, 0, 0, 0, 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    drive(3'd0, '0, '0, 0, 0, 0, 0, 0);
    check40("R1", acc, 40'h0);
    check16("R1", acc_hi, 16'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule